// File: doc/BRIEF.md
# Round-Robin Monitor Channel Sequencer

This block schedules conversions of six monitored analog quantities, one after another, through an abstract converter. The quantities are a temperature, a supply voltage and four general monitor inputs. For each conversion the block raises a start request carrying the channel number and waits for the converter's done strobe and data word. The four monitor channels can each divide their raw result by a power of two with a programmable right shift, which lets a smaller analog span keep a fixed bit weight. The shifted value is stored in that channel's measurement register and checked against the channel's high-alarm, low-alarm and warning thresholds.

Fault outputs downstream can depend on the supply low alarm. When that dependency is enabled, the block starts out of reset in a guarded mode. In that mode it alternates between temperature and supply only, until a supply reading is no longer below its low threshold. After that it runs the full rotation. A one-cycle pulse marks the end of every complete rotation. Thresholds and shift amounts are plain configuration inputs.

Top module: `adc_rr_seq`

## Requirements
- R1: In full mode, channels are converted in the repeating order 0 (temperature), 1 (supply), 2, 3, 4, 5 (monitors one to four), and `conv_chan` shows the channel of each request.
- R2: Monitor k (channel k+1, k = 1..4) is shifted right by `mon_shift[3(k-1)+2 : 3(k-1)]`, from 0 to 7 places. Channels 0 and 1 are never shifted.
- R3: On each accepted conversion, the shifted result is written to that channel's 16-bit slot of `meas`, at bits [16c+15:16c].
- R4: For the converted channel, the high flag is set exactly when the shifted result is greater than its high threshold. The low flag is set exactly when it is less than its low threshold. Threshold slot c sits at bits [16c+15:16c] of each threshold bus.
- R5: For the converted channel, the warning flag is set exactly when the shifted result is greater than its warning threshold.
- R6: A conversion changes the measurement and the three flags of its own channel only. All other channels keep their values.
- R7: With `vlow_gate_en` high, after reset the sequence runs 0,1,0,1,… for as long as each supply result is below the supply low threshold. The first supply result at or above that threshold sends the sequence on to channel 2, and full mode holds until the next reset.
- R8: With `vlow_gate_en` low, the full rotation runs from reset whatever the supply reading.
- R9: `round_done` is high for exactly the one cycle after channel 5's conversion is accepted, and at no other time.
- R10: `conv_start` is a one-cycle pulse. A `conv_done` is accepted only while a request is outstanding, and a stray `conv_done` at any other time has no effect. The registers change on the clock edge that samples `conv_done` high, and the next request follows one cycle later.
- R11: A synchronous active-high `rst` clears all measurements and flags, drops `conv_start` and `round_done`, selects channel 0 and re-enters the guarded mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vlow_gate_en | input | 1 | Supply low alarm drives a fault output; enables guarded start-up |
| mon_shift | input | 12 | Right-shift amounts of monitors one to four, 3 bits each |
| hi_thr | input | 96 | High-alarm thresholds, 16 bits per channel |
| lo_thr | input | 96 | Low-alarm thresholds, 16 bits per channel |
| warn_thr | input | 96 | Warning thresholds, 16 bits per channel |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | 3 | Channel of the current request |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 16 | Raw converter result, valid with `conv_done` |
| meas | output | 96 | Shifted measurements, 16 bits per channel |
| hi_flag | output | 6 | High alarm per channel |
| lo_flag | output | 6 | Low alarm per channel |
| warn_flag | output | 6 | Warning per channel |
| round_done | output | 1 | Full rotation complete pulse |

## Verification
The measurement, flags and `round_done` are registered on the edge that samples `conv_done` high. The bench therefore drives the strobe at a falling edge and compares all six slots and flag vectors one falling edge later. The next `conv_start` is due one cycle after that. The bench looks for it at that cycle, checks the channel number against its own sequencing model, and confirms the pulse has dropped by the following falling edge. A stray strobe is held into the request-issue cycle, and the stored values are re-read one cycle later to show it was ignored.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;
  typedef enum logic [0:0] {ST_ISSUE, ST_WAIT} seq_st_t;
  localparam int CH_TEMP   = 0;
  localparam int CH_SUPPLY = 1;
  localparam int N_FIXED   = 2;
endpackage

// File: rtl/rr_shifter.sv
module rr_shifter #(
  parameter int DATA_W = 16,
  parameter int SH_W   = 3,
  parameter int N_MON  = 4,
  parameter int N_CH   = N_MON + adc_rr_pkg::N_FIXED,
  parameter int CH_W   = $clog2(N_CH)
) (
  input  logic [DATA_W-1:0]     raw,
  input  logic [CH_W-1:0]       chan,
  input  logic [N_MON*SH_W-1:0] mon_shift,
  output logic [DATA_W-1:0]     shifted
);
  logic [SH_W-1:0] amt [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_amt
    if (g < adc_rr_pkg::N_FIXED) begin : g_fixed
      assign amt[g] = '0;
    end else begin : g_mon
      assign amt[g] = mon_shift[(g-adc_rr_pkg::N_FIXED)*SH_W +: SH_W];
    end
  end

  assign shifted = raw >> amt[chan];

  // R2: a right shift can never enlarge the value
  always_comb begin
    a_r2_no_growth: assert (shifted <= raw);
  end
endmodule

// File: rtl/rr_compare.sv
module rr_compare #(
  parameter int DATA_W = 16,
  parameter int N_CH   = 6,
  parameter int CH_W   = $clog2(N_CH)
) (
  input  logic [DATA_W-1:0]      value,
  input  logic [CH_W-1:0]        chan,
  input  logic [N_CH*DATA_W-1:0] hi_thr,
  input  logic [N_CH*DATA_W-1:0] lo_thr,
  input  logic [N_CH*DATA_W-1:0] warn_thr,
  output logic                   hi_hit,
  output logic                   lo_hit,
  output logic                   warn_hit
);
  logic [DATA_W-1:0] hi_a [N_CH];
  logic [DATA_W-1:0] lo_a [N_CH];
  logic [DATA_W-1:0] wr_a [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_unpack
    assign hi_a[g] = hi_thr[g*DATA_W +: DATA_W];
    assign lo_a[g] = lo_thr[g*DATA_W +: DATA_W];
    assign wr_a[g] = warn_thr[g*DATA_W +: DATA_W];
  end

  assign hi_hit   = value > hi_a[chan];
  assign lo_hit   = value < lo_a[chan];
  assign warn_hit = value > wr_a[chan];
endmodule

// File: rtl/rr_chan_ctrl.sv
module rr_chan_ctrl #(
  parameter int N_CH = 6,
  parameter int CH_W = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gate_en,
  input  logic            conv_done,
  input  logic            supply_ok,
  output logic            conv_start,
  output logic [CH_W-1:0] chan,
  output logic            accept,
  output logic            wrap
);
  import adc_rr_pkg::*;

  seq_st_t         st_q;
  logic            start_q;
  logic            guard_q;
  logic [CH_W-1:0] chan_q;
  logic [CH_W-1:0] chan_nx;

  assign accept     = (st_q == ST_WAIT) && conv_done;
  assign wrap       = accept && (chan_q == CH_W'(N_CH-1));
  assign conv_start = start_q;
  assign chan       = chan_q;

  always_comb begin
    if (chan_q == CH_W'(CH_SUPPLY) && guard_q && gate_en && !supply_ok)
      chan_nx = CH_W'(CH_TEMP);
    else if (chan_q == CH_W'(N_CH-1))
      chan_nx = '0;
    else
      chan_nx = chan_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_ISSUE;
      start_q <= 1'b0;
      guard_q <= 1'b1;
      chan_q  <= '0;
    end else begin
      case (st_q)
        ST_ISSUE: begin
          start_q <= 1'b1;
          st_q    <= ST_WAIT;
        end
        default: begin
          start_q <= 1'b0;
          if (conv_done) begin
            st_q   <= ST_ISSUE;
            chan_q <= chan_nx;
            if (chan_q == CH_W'(CH_SUPPLY) && supply_ok)
              guard_q <= 1'b0;
          end
        end
      endcase
    end
  end

  // R10: request is a single-cycle pulse
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R1: channel number stays inside the rotation
  a_r1_chan_range: assert property (@(posedge clk) disable iff (rst)
    chan < CH_W'(N_CH));

  // R7: guarded mode only requests temperature or supply
  a_r7_guarded: assert property (@(posedge clk) disable iff (rst)
    (guard_q && gate_en && conv_start) |-> (chan <= CH_W'(CH_SUPPLY)));
endmodule

// File: rtl/adc_rr_seq.sv
module adc_rr_seq #(
  parameter int DATA_W = 16,
  parameter int SH_W   = 3,
  parameter int N_MON  = 4,
  localparam int N_CH  = N_MON + adc_rr_pkg::N_FIXED,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vlow_gate_en,
  input  logic [N_MON*SH_W-1:0]  mon_shift,
  input  logic [N_CH*DATA_W-1:0] hi_thr,
  input  logic [N_CH*DATA_W-1:0] lo_thr,
  input  logic [N_CH*DATA_W-1:0] warn_thr,
  output logic                   conv_start,
  output logic [CH_W-1:0]        conv_chan,
  input  logic                   conv_done,
  input  logic [DATA_W-1:0]      conv_data,
  output logic [N_CH*DATA_W-1:0] meas,
  output logic [N_CH-1:0]        hi_flag,
  output logic [N_CH-1:0]        lo_flag,
  output logic [N_CH-1:0]        warn_flag,
  output logic                   round_done
);
  logic [DATA_W-1:0] shifted;
  logic              hi_hit, lo_hit, warn_hit;
  logic              accept, wrap;
  logic [DATA_W-1:0] meas_q [N_CH];
  logic [N_CH-1:0]   hi_q, lo_q, warn_q;
  logic              done_q;

  rr_chan_ctrl #(.N_CH(N_CH), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst(rst), .gate_en(vlow_gate_en), .conv_done(conv_done),
    .supply_ok(!lo_hit), .conv_start(conv_start), .chan(conv_chan),
    .accept(accept), .wrap(wrap)
  );

  rr_shifter #(.DATA_W(DATA_W), .SH_W(SH_W), .N_MON(N_MON), .N_CH(N_CH), .CH_W(CH_W)) u_shift (
    .raw(conv_data), .chan(conv_chan), .mon_shift(mon_shift), .shifted(shifted)
  );

  rr_compare #(.DATA_W(DATA_W), .N_CH(N_CH), .CH_W(CH_W)) u_cmp (
    .value(shifted), .chan(conv_chan), .hi_thr(hi_thr), .lo_thr(lo_thr),
    .warn_thr(warn_thr), .hi_hit(hi_hit), .lo_hit(lo_hit), .warn_hit(warn_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_CH; i++) meas_q[i] <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      warn_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= wrap;
      if (accept) begin
        meas_q[conv_chan] <= shifted;
        hi_q[conv_chan]   <= hi_hit;
        lo_q[conv_chan]   <= lo_hit;
        warn_q[conv_chan] <= warn_hit;
      end
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_flat
    assign meas[g*DATA_W +: DATA_W] = meas_q[g];
  end

  assign hi_flag    = hi_q;
  assign lo_flag    = lo_q;
  assign warn_flag  = warn_q;
  assign round_done = done_q;

  // R9: rotation pulse only follows the last channel's conversion
  a_r9_round_src: assert property (@(posedge clk) disable iff (rst)
    round_done |-> ($past(conv_chan) == CH_W'(N_CH-1)) && $past(conv_done));

  // R6: without an accepted conversion, no flag or measurement moves
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(accept) |-> ($stable(hi_flag) && $stable(lo_flag) &&
                        $stable(warn_flag) && $stable(meas)));
endmodule

// File: tb/adc_rr_seq_test.sv
`timescale 1ns/1ps
module adc_rr_seq_test;
  localparam int NC = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vlow_gate_en = 1'b1;
  logic [11:0] mon_shift;
  logic [NC*DW-1:0] hi_thr, lo_thr, warn_thr;
  logic conv_start;
  logic [2:0] conv_chan;
  logic conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic [NC*DW-1:0] meas;
  logic [NC-1:0] hi_flag, lo_flag, warn_flag;
  logic round_done;

  int total = 0;
  int bad = 0;

  logic [DW-1:0] e_meas [NC];
  logic [NC-1:0] e_hi, e_lo, e_warn;
  int e_ch;
  bit e_guard;

  always #4 clk = ~clk;

  adc_rr_seq uut (
    .clk(clk), .rst(rst), .vlow_gate_en(vlow_gate_en), .mon_shift(mon_shift),
    .hi_thr(hi_thr), .lo_thr(lo_thr), .warn_thr(warn_thr),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .meas(meas), .hi_flag(hi_flag), .lo_flag(lo_flag),
    .warn_flag(warn_flag), .round_done(round_done)
  );

  // {latency[3:0], raw[15:0]}
  localparam logic [19:0] VEC [14] = '{
    {4'd1, 16'h2000}, {4'd0, 16'h0800}, {4'd2, 16'h3000}, {4'd1, 16'h2000},
    {4'd3, 16'h0500}, {4'd0, 16'hFFFF}, {4'd1, 16'hFFFF}, {4'd2, 16'hF000},
    {4'd0, 16'hD000}, {4'd1, 16'hB000}, {4'd2, 16'hC100}, {4'd1, 16'h2400},
    {4'd0, 16'h8000}, {4'd3, 16'hFFFF}
  };

  function automatic logic [DW-1:0] th_hi(int c);   return 16'hC000 - 16'(c*256); endfunction
  function automatic logic [DW-1:0] th_lo(int c);   return 16'h1000 + 16'(c*256); endfunction
  function automatic logic [DW-1:0] th_warn(int c); return 16'hA000 + 16'(c*16);  endfunction
  function automatic int shamt(int c);
    return (c < 2) ? 0 : int'(mon_shift[(c-2)*3 +: 3]);
  endfunction

  function automatic logic [NC*DW-1:0] e_flat();
    logic [NC*DW-1:0] f;
    for (int i = 0; i < NC; i++) f[i*DW +: DW] = e_meas[i];
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NC; i++) e_meas[i] = '0;
    e_hi = '0; e_lo = '0; e_warn = '0;
    e_ch = 0; e_guard = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    model_reset();
    // R11: reset state
    chk(conv_start == 1'b0 && round_done == 1'b0, "R11 start/round", {conv_start, round_done}, 0);
    chk(conv_chan == 3'd0, "R11 chan", conv_chan, 0);
    chk(meas == '0 && hi_flag == '0 && lo_flag == '0 && warn_flag == '0, "R11 regs",
        {hi_flag, lo_flag, warn_flag}, 0);
    rst = 1'b0;
  endtask

  // called at a falling edge
  task automatic convert(input logic [DW-1:0] raw, input int lat, input bit stray);
    int waited = 0;
    logic [DW-1:0] v;
    bit last;
    while (!conv_start && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk(conv_start == 1'b1, "R10 request seen", conv_start, 1);
    // R1 R7 R8: channel order from the model
    chk(int'(conv_chan) == e_ch, "R1/R7/R8 channel", conv_chan, e_ch);
    if (lat > 0) begin
      @(negedge clk);
      chk(conv_start == 1'b0, "R10 pulse width", conv_start, 0);
      repeat (lat - 1) @(negedge clk);
    end
    conv_done = 1'b1;
    conv_data = raw;
    @(negedge clk);
    v = raw >> shamt(e_ch);
    e_meas[e_ch] = v;
    e_hi[e_ch]   = v > th_hi(e_ch);
    e_lo[e_ch]   = v < th_lo(e_ch);
    e_warn[e_ch] = v > th_warn(e_ch);
    last = (e_ch == NC - 1);
    if (e_ch == 1) begin
      if (e_guard && vlow_gate_en && v < th_lo(1)) e_ch = 0;
      else e_ch = 2;
      if (v >= th_lo(1)) e_guard = 1'b0;
    end else begin
      e_ch = last ? 0 : e_ch + 1;
    end
    // R2 R3 R6: all slots match the model
    chk(meas == e_flat(), "R2/R3/R6 meas", meas, e_flat());
    chk(hi_flag == e_hi && lo_flag == e_lo, "R4/R6 hi lo", {hi_flag, lo_flag}, {e_hi, e_lo});
    chk(warn_flag == e_warn, "R5/R6 warn", warn_flag, e_warn);
    chk(round_done == last, "R9 round pulse", round_done, last);
    if (stray) begin
      conv_data = ~raw;
      @(negedge clk);
      conv_done = 1'b0;
      // R10: strobe during issue cycle ignored
      chk(meas == e_flat() && hi_flag == e_hi && lo_flag == e_lo, "R10 stray ignored", meas, e_flat());
      chk(round_done == 1'b0, "R9 pulse one cycle", round_done, 0);
    end else begin
      conv_done = 1'b0;
    end
  endtask

  initial begin
    mon_shift = {3'd7, 3'd3, 3'd1, 3'd0};
    for (int i = 0; i < NC; i++) begin
      hi_thr[i*DW +: DW]   = th_hi(i);
      lo_thr[i*DW +: DW]   = th_lo(i);
      warn_thr[i*DW +: DW] = th_warn(i);
    end
    do_reset();
    for (int k = 0; k < 14; k++)
      convert(VEC[k][15:0], int'(VEC[k][19:16]), k == 6);

    // R8: gate disabled, low supply does not restrict the order
    vlow_gate_en = 1'b0;
    do_reset();
    convert(16'h0100, 1, 1'b0);
    convert(16'h0100, 0, 1'b0);
    convert(16'h4000, 2, 1'b1);
    convert(16'h0080, 1, 1'b0);
    convert(16'hFF00, 0, 1'b0);
    convert(16'h9000, 1, 1'b0);

    // R7: guarded again after reset, stays while supply low
    vlow_gate_en = 1'b1;
    do_reset();
    convert(16'h1234, 1, 1'b0);
    convert(16'h10FF, 1, 1'b0);
    convert(16'h4321, 0, 1'b1);
    convert(16'h1100, 2, 1'b0);
    convert(16'h0001, 1, 1'b0);
    convert(16'h0000, 1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule